// File: doc/BRIEF.md
# Immediate Operand Extension Unit

A combinational unit inside an integer decode path. It takes the raw immediate bytes of an instruction, together with the immediate length, the operation width and a flag that marks the move-constant-into-register form. From these it produces the 64-bit operand that is handed to execution. Short immediates are sign-extended to the operation width. Bits above the operation width are cleared. A 4-byte immediate on a 64-bit operation is sign-extended from bit 31.

The full 8-byte immediate is legal only for the move-into-register form at 64-bit width, where it passes through unchanged. Any other use of an 8-byte immediate raises an error output. A separate flag tells the encoder whether the full 64-bit raw value could be expressed as a sign-extended 32-bit immediate, meaning bits 63 down to 31 are all equal. The flag is also high when the 64-bit move form is selected, because that form carries all 64 bits.

Field encodings: `imm_len_i` uses 0=1 byte, 1=2 bytes, 2=4 bytes, 3=8 bytes. `op_size_i` uses 0=8 bits, 1=16 bits, 2=32 bits, 3=64 bits. The immediate always sits in the low bytes of `imm_raw_i`.

Top module: `imm_ext_unit`

## Requirements
- R1: With `imm_len_i`=0, `operand_o` is bits 7:0 of `imm_raw_i` sign-extended from bit 7 up to the width chosen by `op_size_i`.
- R2: With `imm_len_i`=1, `operand_o` is bits 15:0 sign-extended from bit 15 up to the width chosen by `op_size_i`.
- R3: With `imm_len_i`=2 and `op_size_i`=3, `operand_o` is bits 31:0 sign-extended from bit 31 to 64 bits.
- R4: With `imm_len_i`=2 and `op_size_i`=2, `operand_o[31:0]` equals `imm_raw_i[31:0]` and `operand_o[63:32]` is zero.
- R5: Every bit of `operand_o` at or above the width chosen by `op_size_i` (8, 16, 32, 64) is zero. An immediate wider than the operation is truncated to the operation width.
- R6: With `imm_len_i`=3, `mov_form_i`=1 and `op_size_i`=3, `operand_o` equals `imm_raw_i` and `len_err_o` is 0.
- R7: With `imm_len_i`=3 and any other combination of `mov_form_i` and `op_size_i`, `len_err_o` is 1 and `operand_o` is zero. For every other length, `len_err_o` is 0.
- R8: `encodable_o` is 1 when `imm_raw_i[63:31]` are all equal. Examples: an all-ones value gives 1, while 0x00000000FFFFFFFF and 0x0000000080000000 give 0 when the 64-bit move form is not selected.
- R9: With `mov_form_i`=1 and `op_size_i`=3, `encodable_o` is 1 for any `imm_raw_i`.
- R10: Bytes of `imm_raw_i` above the selected immediate length have no effect on `operand_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| imm_raw_i | input | 64 | Raw immediate, value held in the low bytes |
| imm_len_i | input | 2 | Immediate length code (0=1B, 1=2B, 2=4B, 3=8B) |
| op_size_i | input | 2 | Operation width code (0=8b, 1=16b, 2=32b, 3=64b) |
| mov_form_i | input | 1 | Move-constant-into-register form |
| operand_o | output | 64 | Extended operand |
| encodable_o | output | 1 | Raw 64-bit value fits a sign-extended 32-bit immediate, or the 64-bit move form is selected |
| len_err_o | output | 1 | 8-byte immediate used outside the 64-bit move form |

## Verification
Whenever the inputs settle, the assertions check four things: the operand is cleared above the operation width, an error forces a zero operand, the 64-bit move form passes the raw value through and sets the encodable flag, and a 4-byte immediate at 64-bit width fills the upper half with copies of bit 31. Only the bench scenarios can show the rest. That includes exact sign extension of short immediates across every width, truncation of immediates wider than the operation, indifference to the bytes above the immediate length, and the encodable boundary values around bit 31. The bench covers these with directed values and a random sweep, checked against a bit-loop model.

// File: rtl/imm_ext_pkg.sv
package imm_ext_pkg;
  localparam int unsigned IMM_DATA_W = 64;
  localparam int unsigned IMM_SIMM_W = 32;
  localparam int unsigned IMM_NUM_W  = 4;
  localparam int unsigned IMM_SEL_W  = $clog2(IMM_NUM_W);

  typedef enum logic [IMM_SEL_W-1:0] {
    WSEL_8  = 2'd0,
    WSEL_16 = 2'd1,
    WSEL_32 = 2'd2,
    WSEL_64 = 2'd3
  } wsel_e;
endpackage

// File: rtl/imm_sext.sv
// Sign-extends the low 8<<k bits of the raw field, k picked by len_i.
module imm_sext #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned NUM_W  = 4,
  localparam int unsigned SEL_W = $clog2(NUM_W)
) (
  input  logic [DATA_W-1:0] raw_i,
  input  logic [SEL_W-1:0]  len_i,
  output logic [DATA_W-1:0] ext_o
);
  logic [DATA_W-1:0] cand [NUM_W];

  for (genvar g = 0; g < NUM_W; g++) begin : g_len
    localparam int unsigned B = 8 << g;
    logic signed [B-1:0] slice;
    assign slice   = raw_i[B-1:0];
    assign cand[g] = DATA_W'(slice);
  end

  assign ext_o = cand[len_i];
endmodule

// File: rtl/imm_size_mask.sv
// Clears bits at and above the operation width.
module imm_size_mask #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned NUM_W  = 4,
  localparam int unsigned SEL_W = $clog2(NUM_W)
) (
  input  logic [DATA_W-1:0] val_i,
  input  logic [SEL_W-1:0]  size_i,
  output logic [DATA_W-1:0] val_o
);
  logic [DATA_W-1:0] mask [NUM_W];

  for (genvar g = 0; g < NUM_W; g++) begin : g_mask
    localparam int unsigned B = 8 << g;
    if (B >= DATA_W) begin : g_full
      assign mask[g] = '1;
    end else begin : g_part
      assign mask[g] = {{(DATA_W-B){1'b0}}, {B{1'b1}}};
    end
  end

  assign val_o = val_i & mask[size_i];
endmodule

// File: rtl/imm_fit_chk.sv
// High when the value survives a round trip through a SIMM_W-bit signed field.
module imm_fit_chk #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned SIMM_W = 32
) (
  input  logic [DATA_W-1:0] val_i,
  output logic              fits_o
);
  logic [DATA_W-SIMM_W:0] top_bits;
  assign top_bits = val_i[DATA_W-1:SIMM_W-1];
  assign fits_o   = (&top_bits) | ~(|top_bits);
endmodule

// File: rtl/imm_ext_unit.sv
module imm_ext_unit
  import imm_ext_pkg::*;
#(
  parameter int unsigned DATA_W = IMM_DATA_W,
  parameter int unsigned SIMM_W = IMM_SIMM_W,
  parameter int unsigned NUM_W  = IMM_NUM_W,
  localparam int unsigned SEL_W = $clog2(NUM_W)
) (
  input  logic [DATA_W-1:0] imm_raw_i,
  input  logic [SEL_W-1:0]  imm_len_i,
  input  logic [SEL_W-1:0]  op_size_i,
  input  logic              mov_form_i,
  output logic [DATA_W-1:0] operand_o,
  output logic              encodable_o,
  output logic              len_err_o
);
  localparam logic [SEL_W-1:0] SEL_FULL = SEL_W'(NUM_W - 1);

  logic [DATA_W-1:0] ext_val;
  logic [DATA_W-1:0] sized_val;
  logic              fits_simm;
  logic              wide_move;
  logic              full_len;

  imm_sext #(.DATA_W(DATA_W), .NUM_W(NUM_W)) u_sext (
    .raw_i (imm_raw_i),
    .len_i (imm_len_i),
    .ext_o (ext_val)
  );

  imm_size_mask #(.DATA_W(DATA_W), .NUM_W(NUM_W)) u_mask (
    .val_i  (ext_val),
    .size_i (op_size_i),
    .val_o  (sized_val)
  );

  imm_fit_chk #(.DATA_W(DATA_W), .SIMM_W(SIMM_W)) u_fit (
    .val_i  (imm_raw_i),
    .fits_o (fits_simm)
  );

  // only the full-width move may carry a full-width immediate
  assign wide_move   = mov_form_i && (op_size_i == SEL_FULL);
  assign full_len    = (imm_len_i == SEL_FULL);
  assign len_err_o   = full_len && !wide_move;
  assign operand_o   = len_err_o ? '0 : sized_val;
  assign encodable_o = fits_simm || wide_move;
endmodule

// File: rtl/imm_ext_unit_chk.sv
module imm_ext_unit_chk #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned SIMM_W = 32,
  parameter int unsigned NUM_W  = 4,
  localparam int unsigned SEL_W = $clog2(NUM_W)
) (
  input logic [DATA_W-1:0] imm_raw_i,
  input logic [SEL_W-1:0]  imm_len_i,
  input logic [SEL_W-1:0]  op_size_i,
  input logic              mov_form_i,
  input logic [DATA_W-1:0] operand_o,
  input logic              encodable_o,
  input logic              len_err_o
);
  localparam logic [SEL_W-1:0] SEL_FULL = SEL_W'(NUM_W - 1);
  localparam logic [SEL_W-1:0] SEL_HALF = SEL_W'(NUM_W - 2);

  logic known;
  logic wide;
  int unsigned op_bits;

  always_comb begin
    known   = !$isunknown({imm_raw_i, imm_len_i, op_size_i, mov_form_i});
    wide    = mov_form_i && (op_size_i == SEL_FULL);
    op_bits = 8 << op_size_i;
    if (known) begin
      // R5
      upper_zero_chk: assert ((op_bits >= DATA_W) || ((operand_o >> op_bits) == '0));
      // R7
      err_zero_chk: assert (!len_err_o || (operand_o == '0));
      // R7
      err_len_chk: assert (!len_err_o || (imm_len_i == SEL_FULL));
      // R9
      wide_enc_chk: assert (!wide || encodable_o);
      // R6
      wide_pass_chk: assert (!(wide && imm_len_i == SEL_FULL) || (operand_o == imm_raw_i && !len_err_o));
      // R3
      simm_hi_chk: assert (!(op_size_i == SEL_FULL && imm_len_i == SEL_HALF)
                           || (operand_o[DATA_W-1:SIMM_W] == {(DATA_W-SIMM_W){imm_raw_i[SIMM_W-1]}}));
      // R1
      byte_low_chk: assert (!(imm_len_i == '0) || (operand_o[7:0] == imm_raw_i[7:0]));
    end
  end
endmodule

bind imm_ext_unit imm_ext_unit_chk #(
  .DATA_W (DATA_W),
  .SIMM_W (SIMM_W),
  .NUM_W  (NUM_W)
) chk_i (
  .imm_raw_i   (imm_raw_i),
  .imm_len_i   (imm_len_i),
  .op_size_i   (op_size_i),
  .mov_form_i  (mov_form_i),
  .operand_o   (operand_o),
  .encodable_o (encodable_o),
  .len_err_o   (len_err_o)
);

// File: tb/imm_ext_unit_tb_top.sv
`timescale 1ns/1ps
module imm_ext_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [63:0] imm_raw;
  logic [1:0]  imm_len;
  logic [1:0]  op_size;
  logic        mov_form;
  logic [63:0] operand;
  logic        encodable;
  logic        len_err;
  logic        chk_en = 1'b0;
  string       tag = "R5";
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  imm_ext_unit dut_i (
    .imm_raw_i   (imm_raw),
    .imm_len_i   (imm_len),
    .op_size_i   (op_size),
    .mov_form_i  (mov_form),
    .operand_o   (operand),
    .encodable_o (encodable),
    .len_err_o   (len_err)
  );

  function automatic logic [65:0] ref_model(logic [63:0] raw, int len, int size, bit mov);
    logic [63:0] v;
    int ibits = 8 << len;
    int obits = 8 << size;
    bit wide = mov && (size == 3);
    bit err  = (len == 3) && !wide;
    bit enc  = wide || (raw[63:31] == '0) || (raw[63:31] == '1);
    for (int i = 0; i < 64; i++) begin
      if (i >= obits)      v[i] = 1'b0;
      else if (i < ibits)  v[i] = raw[i];
      else                 v[i] = raw[ibits-1];
    end
    if (err) v = '0;
    return {err, enc, v};
  endfunction

  // reference compared on every clock
  always @(posedge clk) begin
    if (rst_ni && chk_en && !done) begin
      logic [65:0] e;
      e = ref_model(imm_raw, int'(imm_len), int'(op_size), mov_form);
      n_chk++;
      if ({len_err, encodable, operand} !== e) begin
        n_fail++;
        $display("FAIL %s raw=%h len=%0d size=%0d mov=%0b: err/enc/op=%b/%b/%h exp=%b/%b/%h",
                 tag, imm_raw, imm_len, op_size, mov_form, len_err, encodable, operand,
                 e[65], e[64], e[63:0]);
      end
    end
  end

  task automatic apply(input string t, input logic [63:0] raw, input int len, input int size, input bit mov);
    @(negedge clk);
    tag = t; imm_raw = raw; imm_len = 2'(len); op_size = 2'(size); mov_form = mov;
    chk_en = 1'b1;
    @(posedge clk);
  endtask

  task automatic expect_op(input string t, input logic [63:0] exp);
    #1;
    n_chk++;
    if (operand !== exp) begin
      n_fail++;
      $display("FAIL %s operand=%h exp=%h", t, operand, exp);
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(4ns * 200000);
    n_fail++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    finish_run();
  end

  initial begin
    imm_raw = '0; imm_len = '0; op_size = '0; mov_form = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    n_chk++;
    if (operand !== '0 || len_err !== 1'b0 || encodable !== 1'b1) begin
      n_fail++;
      $display("FAIL reset idle: op=%h err=%b enc=%b exp=0/0/1", operand, len_err, encodable);
    end

    // R1 byte immediates
    apply("R1", 64'h80, 0, 3, 0); expect_op("R1", 64'hFFFF_FFFF_FFFF_FF80);
    apply("R1", 64'h80, 0, 1, 0); expect_op("R1", 64'h0000_0000_0000_FF80);
    apply("R1", 64'h80, 0, 0, 0); expect_op("R1", 64'h80);
    apply("R1", 64'h7F, 0, 3, 0); expect_op("R1", 64'h7F);
    // R2 word immediates
    apply("R2", 64'h8001, 1, 2, 0); expect_op("R2", 64'hFFFF_8001);
    apply("R2", 64'h8001, 1, 3, 0); expect_op("R2", 64'hFFFF_FFFF_FFFF_8001);
    // R3 dword at 64-bit
    apply("R3", 64'h8000_0000, 2, 3, 0); expect_op("R3", 64'hFFFF_FFFF_8000_0000);
    apply("R3", 64'h7FFF_FFFF, 2, 3, 0); expect_op("R3", 64'h7FFF_FFFF);
    // R4 dword at 32-bit
    apply("R4", 64'hFFFF_FFFF, 2, 2, 0); expect_op("R4", 64'h0000_0000_FFFF_FFFF);
    apply("R4", 64'hFFFF_FFFF, 2, 2, 1); expect_op("R4", 64'h0000_0000_FFFF_FFFF);
    // R5 truncation to narrow operation
    apply("R5", 64'h1234_5681, 2, 0, 0); expect_op("R5", 64'h81);
    apply("R5", 64'hFFFF_8000, 1, 0, 0); expect_op("R5", 64'h00);
    // R6 full move
    apply("R6", 64'h1122_3344_5566_7788, 3, 3, 1); expect_op("R6", 64'h1122_3344_5566_7788);
    // R7 illegal full-length use
    apply("R7", 64'h1122_3344_5566_7788, 3, 3, 0); expect_op("R7", 64'h0);
    apply("R7", 64'hFFFF_FFFF_FFFF_FFFF, 3, 2, 1); expect_op("R7", 64'h0);
    // R8 encodability boundary
    apply("R8", 64'hFFFF_FFFF_FFFF_FFFF, 2, 3, 0);
    apply("R8", 64'h0000_0000_FFFF_FFFF, 2, 3, 0);
    apply("R8", 64'hFFFF_FFFF_8000_0000, 2, 3, 0);
    apply("R8", 64'h0000_0000_8000_0000, 2, 3, 0);
    apply("R8", 64'h0000_0000_7FFF_FFFF, 2, 3, 0);
    // R9 move form always encodable
    apply("R9", 64'h0000_0000_FFFF_FFFF, 3, 3, 1);
    apply("R9", 64'h8000_0000_0000_0000, 2, 3, 1);
    // R10 junk above immediate length
    apply("R10", 64'hDEAD_BEEF_CAFE_1280, 0, 3, 0); expect_op("R10", 64'hFFFF_FFFF_FFFF_FF80);
    apply("R10", 64'hDEAD_BEEF_0000_7FFE, 1, 2, 0); expect_op("R10", 64'h7FFE);
    apply("R10", 64'hDEAD_BEEF_8765_4321, 2, 3, 0); expect_op("R10", 64'hFFFF_FFFF_8765_4321);
    // random sweep against the model
    for (int k = 0; k < 400; k++) begin
      apply("R5", {$urandom, $urandom}, int'($urandom_range(0, 3)), int'($urandom_range(0, 3)),
            1'($urandom_range(0, 1)));
    end
    @(negedge clk);
    chk_en = 1'b0;
    finish_run();
  end
endmodule